// File: doc/BRIEF.md
# Banked ROM Mapper with On-Chip Nibble RAM

This block sits between a CPU's 16-bit address bus and a banked program ROM. It turns each CPU address in the program window into a physical ROM address. The lower 16 KiB of the window always reaches the start of the ROM. The upper 16 KiB reaches whichever bank the CPU last selected. The block owns no ROM storage. It only drives `rom_addr` and `rom_hit`, and the ROM device returns the bytes.

Software configures the block by writing into the lower program window. Address bit 8 of each such write picks between two targets: the RAM enable latch and the ROM bank register. The block also contains a 512-entry by 4-bit RAM. This RAM answers every address in the external RAM window, so the window repeats the 512 entries over its whole 8 KiB. Each write stores only the low nibble of the data. On a read, the high nibble comes back as ones. While the RAM is disabled, reads return all ones and writes are dropped.

Top module: `nibmap_top`

## Requirements
- R1: After reset the selected ROM bank is 1 and the RAM is disabled: address 0x4000 maps to ROM address 0x04000, and a read at 0xA000 returns 0xFF.
- R2: A write in 0x0000–0x3FFF with address bit 8 = 0 sets the RAM enable latch. The latch turns on only when the full data byte equals 0x0A. Any other byte, 0x1A for example, turns it off. The bank register is unchanged.
- R3: A write in 0x0000–0x3FFF with address bit 8 = 1 loads the bank register from data bits [3:0]. Data bits [7:4] are ignored and the RAM enable latch is unchanged.
- R4: A bank value of 0 is stored as 1, so the upper window never maps onto bank 0.
- R5: The nibble is first ANDed with ROM_BANKS−1 (ROM_BANKS is a power of two from 2 to 16). The zero rule of R4 is applied after this masking. With ROM_BANKS = 4, data 0x06 selects bank 2 and data 0x04 selects bank 1.
- R6: For addresses 0x0000–0x3FFF, rom_addr equals the address. For 0x4000–0x7FFF, rom_addr = bank × 0x4000 + (address & 0x3FFF).
- R7: rom_hit is 1 exactly for addresses 0x0000–0x7FFF. ram_hit is 1 exactly for 0xA000–0xBFFF.
- R8: The RAM holds 512 entries indexed by address bits [8:0]. Every address in 0xA000–0xBFFF whose low 9 bits are equal reaches the same entry.
- R9: While the RAM is disabled, a read in the RAM window returns 0xFF and a write there leaves the stored entry unchanged.
- R10: A RAM write stores data bits [3:0]. A read with the RAM enabled returns {4'hF, stored nibble}. Reads outside the RAM window return 0xFF.
- R11: Writes to 0x4000–0x9FFF or 0xC000–0xFFFF change neither the bank, the enable latch nor the RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe, one write per cycle while high |
| rom_addr | output | ROM_AW | Physical ROM byte address (0 when rom_hit is low) |
| rom_hit | output | 1 | Address falls in the program window |
| ram_hit | output | 1 | Address falls in the RAM window |
| ram_rdata | output | 8 | Combinational read data from the nibble RAM |

## Verification
Some properties are checked on every cycle: the bank register never holds zero, and each control target changes only on its own kind of write. The checks also cover the read-data high nibble always being ones, and a disabled RAM always reading 0xFF. The address mapping of the lower window is checked against the bus address on every cycle. Other behaviour only the directed scenarios can show. This covers the mirroring of one entry across several window addresses and the masking result on a small-ROM instance. It also covers a write dropped while the RAM was disabled, which becomes visible only after the RAM is enabled again.

// File: rtl/nibmap_pkg.sv
package nibmap_pkg;

    // Address regions seen by the mapper
    typedef enum logic [1:0] {
        RGN_ROM0 = 2'd0,   // 0x0000-0x3FFF: fixed ROM, control writes
        RGN_ROMX = 2'd1,   // 0x4000-0x7FFF: banked ROM
        RGN_RAM  = 2'd2,   // 0xA000-0xBFFF: nibble RAM window
        RGN_NONE = 2'd3    // everything else
    } region_e;

    localparam logic [7:0] RAM_ON_KEY   = 8'h0A;
    localparam int         NRAM_DEPTH   = 512;
    localparam int         NRAM_AW      = 9;
    localparam int         NIB_W        = 4;
    localparam int         BANK_OFS_W   = 14;

endpackage

// File: rtl/nibmap_decode.sv
module nibmap_decode
    import nibmap_pkg::*;
(
    input  logic [15:0] addr,
    output region_e     region
);
    always_comb begin
        unique casez (addr[15:13])
            3'b00?:  region = RGN_ROM0;
            3'b01?:  region = RGN_ROMX;
            3'b101:  region = RGN_RAM;
            default: region = RGN_NONE;
        endcase
    end
endmodule

// File: rtl/nibmap_ctrl.sv
module nibmap_ctrl
    import nibmap_pkg::*;
#(
    parameter int ROM_BANKS = 16,
    localparam int BW = (ROM_BANKS > 2) ? $clog2(ROM_BANKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  region_e       region,
    input  logic          target_bank,   // address bit 8
    input  logic [7:0]    wdata,
    output logic [BW-1:0] bank_q,
    output logic          ram_en_q
);
    typedef struct packed {
        logic [BW-1:0] bank;
        logic          ram_en;
    } ctrl_s;

    localparam logic [3:0] BANK_MASK = 4'(ROM_BANKS - 1);

    ctrl_s st_d, st_q;
    logic [3:0] nib_masked;
    logic       ctl_wr;

    assign ctl_wr = wr && (region == RGN_ROM0);

    always_comb begin
        st_d       = st_q;
        nib_masked = wdata[3:0] & BANK_MASK;
        if (nib_masked == 4'd0) begin
            nib_masked = 4'd1;
        end
        if (ctl_wr) begin
            if (target_bank) begin
                st_d.bank = nib_masked[BW-1:0];
            end else begin
                st_d.ram_en = (wdata == RAM_ON_KEY);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bank: BW'(1), ram_en: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_q   = st_q.bank;
    assign ram_en_q = st_q.ram_en;

    assert_bank_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q != '0);

    assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && region == RGN_ROM0 && !target_bank) |=> $stable(ram_en_q));

    assert_en_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RGN_ROM0 && !target_bank && wdata == RAM_ON_KEY) |=> ram_en_q);

    assert_bank_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && region == RGN_ROM0 && target_bank) |=> $stable(bank_q));

endmodule

// File: rtl/nibmap_nram.sv
module nibmap_nram #(
    parameter int DEPTH = 512,
    parameter int W     = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/nibmap_top.sv
module nibmap_top
    import nibmap_pkg::*;
#(
    parameter int ROM_BANKS = 16,
    localparam int BW     = (ROM_BANKS > 2) ? $clog2(ROM_BANKS) : 1,
    localparam int ROM_AW = BW + BANK_OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_hit,
    output logic              ram_hit,
    output logic [7:0]        ram_rdata
);
    region_e          region;
    logic [BW-1:0]    bank_q;
    logic             ram_en_q;
    logic [NIB_W-1:0] nib_rd;
    logic             nram_we;

    nibmap_decode u_decode (
        .addr   (bus_addr),
        .region (region)
    );

    nibmap_ctrl #(.ROM_BANKS(ROM_BANKS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (bus_wr),
        .region      (region),
        .target_bank (bus_addr[8]),
        .wdata       (bus_wdata),
        .bank_q      (bank_q),
        .ram_en_q    (ram_en_q)
    );

    assign nram_we = bus_wr && ram_en_q && (region == RGN_RAM);

    nibmap_nram #(.DEPTH(NRAM_DEPTH), .W(NIB_W)) u_nram (
        .clk   (clk),
        .we    (nram_we),
        .waddr (bus_addr[NRAM_AW-1:0]),
        .wdata (bus_wdata[NIB_W-1:0]),
        .raddr (bus_addr[NRAM_AW-1:0]),
        .rdata (nib_rd)
    );

    always_comb begin
        rom_hit   = (region == RGN_ROM0) || (region == RGN_ROMX);
        ram_hit   = (region == RGN_RAM);
        rom_addr  = '0;
        ram_rdata = 8'hFF;
        unique case (region)
            RGN_ROM0: rom_addr = {{BW{1'b0}}, bus_addr[BANK_OFS_W-1:0]};
            RGN_ROMX: rom_addr = {bank_q, bus_addr[BANK_OFS_W-1:0]};
            RGN_RAM:  if (ram_en_q) ram_rdata = {4'hF, nib_rd};
            default:  ;
        endcase
    end

    assert_off_reads_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_en_q |-> ram_rdata == 8'hFF);

    assert_high_nibble_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rdata[7:4] == 4'hF);

    assert_direct_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[15:14] == 2'b00) |-> rom_addr == ROM_AW'(bus_addr[13:0]));

    assert_hit_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_hit && ram_hit));

endmodule

// File: tb/nibmap_top_bench.sv
`timescale 1ns/1ps
module nibmap_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic [7:0]  bus_wdata = 8'h0;
    logic        bus_wr = 1'b0;

    logic [17:0] rom_addr;
    logic        rom_hit, ram_hit;
    logic [7:0]  ram_rdata;
    logic [15:0] s_rom_addr;
    logic        s_rom_hit, s_ram_hit;
    logic [7:0]  s_ram_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    nibmap_top u_nibmap_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .rom_addr(rom_addr), .rom_hit(rom_hit),
        .ram_hit(ram_hit), .ram_rdata(ram_rdata)
    );

    nibmap_top #(.ROM_BANKS(4)) u_nibmap_top_small (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .rom_addr(s_rom_addr), .rom_hit(s_rom_hit),
        .ram_hit(s_ram_hit), .ram_rdata(s_ram_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic look(input logic [15:0] a);
        @(negedge clk);
        bus_addr = a;
        #1;
    endtask

    task automatic t_reset;
        look(16'h4000);
        chk("R1 bank after reset", 32'(rom_addr), 32'h04000);
        chk("R7 rom_hit at 0x4000", 32'(rom_hit), 1);
        look(16'hA000);
        chk("R1 ram off after reset", 32'(ram_rdata), 32'hFF);
        chk("R7 ram_hit at 0xA000", 32'(ram_hit), 1);
    endtask

    task automatic t_bank;
        bus_write(16'h2100, 8'h05);
        look(16'h4ABC);
        chk("R3 R6 bank 5 mapping", 32'(rom_addr), 32'h14ABC);
        bus_write(16'h2100, 8'hF7);
        look(16'h7FFF);
        chk("R3 upper data bits ignored", 32'(rom_addr), 32'h1FFFF);
        look(16'h1234);
        chk("R6 direct window", 32'(rom_addr), 32'h01234);
        look(16'h8000);
        chk("R7 rom_hit at 0x8000", 32'(rom_hit), 0);
        chk("R7 ram_hit at 0x8000", 32'(ram_hit), 0);
    endtask

    task automatic t_zero;
        bus_write(16'h3100, 8'h00);
        look(16'h4000);
        chk("R4 zero becomes one", 32'(rom_addr), 32'h04000);
        bus_write(16'h3F00, 8'h10);
        look(16'h4001);
        chk("R4 nibble zero becomes one", 32'(rom_addr), 32'h04001);
    endtask

    task automatic t_mask;
        bus_write(16'h2100, 8'h06);
        look(16'h4000);
        chk("R5 small rom masked 6->2", 32'(s_rom_addr), 32'h8000);
        chk("R5 full rom keeps 6", 32'(rom_addr), 32'h18000);
        bus_write(16'h2100, 8'h04);
        look(16'h4000);
        chk("R5 small rom masked 4->0->1", 32'(s_rom_addr), 32'h4000);
        chk("R5 full rom keeps 4", 32'(rom_addr), 32'h10000);
    endtask

    task automatic t_ctrl_sel;
        bus_write(16'h0100, 8'h0A);
        look(16'h4000);
        chk("R3 bit8 set loads bank", 32'(rom_addr), 32'h28000);
        look(16'hA000);
        chk("R3 bit8 set leaves ram off", 32'(ram_rdata), 32'hFF);
        bus_write(16'h0000, 8'h03);
        look(16'h4000);
        chk("R2 enable write keeps bank", 32'(rom_addr), 32'h28000);
    endtask

    task automatic t_ram;
        bus_write(16'h0000, 8'h0A);
        bus_write(16'hA005, 8'h3C);
        look(16'hA005);
        chk("R10 nibble stored, high ones", 32'(ram_rdata), 32'hFC);
        look(16'hA205);
        chk("R8 mirror at 0xA205", 32'(ram_rdata), 32'hFC);
        look(16'hBE05);
        chk("R8 mirror at 0xBE05", 32'(ram_rdata), 32'hFC);
        bus_write(16'hA1FF, 8'h09);
        look(16'hBFFF);
        chk("R8 last entry mirror", 32'(ram_rdata), 32'hF9);
        look(16'hA005);
        chk("R8 entries independent", 32'(ram_rdata), 32'hFC);
        look(16'hC005);
        chk("R10 outside window reads ff", 32'(ram_rdata), 32'hFF);
    endtask

    task automatic t_off;
        bus_write(16'h1000, 8'h1A);
        look(16'hA005);
        chk("R2 0x1A disables", 32'(ram_rdata), 32'hFF);
        bus_write(16'hA005, 8'h07);
        bus_write(16'h1E00, 8'h0A);
        look(16'hA005);
        chk("R9 write while off dropped", 32'(ram_rdata), 32'hFC);
    endtask

    task automatic t_ignore;
        bus_write(16'h5100, 8'h03);
        bus_write(16'h9100, 8'h02);
        bus_write(16'hC100, 8'h05);
        bus_write(16'hE000, 8'h00);
        bus_write(16'h6000, 8'h00);
        look(16'h4000);
        chk("R11 bank unchanged", 32'(rom_addr), 32'h28000);
        look(16'hA000);
        chk("R11 ram still on", 32'(ram_hit), 1);
        look(16'hA100);
        chk("R11 ram entry untouched", 32'(ram_rdata[7:4]), 32'hF);
        look(16'hA005);
        chk("R11 ram value kept", 32'(ram_rdata), 32'hFC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bank();
        t_zero();
        t_mask();
        t_ctrl_sel();
        t_ram();
        t_off();
        t_ignore();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule